// File: doc/BRIEF.md
# Dual Wiper Register Slave on a Two-Wire Serial Bus

This block is a bus slave for a two-wire serial bus of the I2C kind. It holds two 6-bit wiper settings and one 6-bit configuration value for an audio attenuator. SCL and SDA are sampled by a fast system clock, and the block pulls SDA low through an open-drain output enable. Three strap inputs set the low bits of the device address. An active-low select input turns the bus interface on or off.

There is no address pointer. On a write, the top two bits of each data byte name the register the byte is for, and the low six bits are the new value. A transaction can carry any number of such bytes, in any order. A read returns the two wipers and then the configuration value. Each returned byte carries its own selector in its top two bits. The sequence repeats for as long as the master keeps acknowledging.

The stored values and a one-cycle write strobe for each register go to the attenuator logic next to the block.

Top module: `wpot_i2c_regs`

## Requirements
- R1: The block acknowledges an address byte whose top seven bits equal binary 0101 followed by strap[2:0]. Bit 0 of that byte selects read (1) or write (0).
- R2: After an address byte that does not match, the block neither acknowledges nor stores anything until the next START.
- R3: While cs_n is high, the block never drives SDA and stores nothing.
- R4: A write data byte with bits [7:6] equal to 00, 01 or 10 loads bits [5:0] into wiper0, wiper1 or cfg_val. It also pulses wr_stb[0], wr_stb[1] or wr_stb[2] for exactly one clock, and at most one strobe bit is high at any time.
- R5: A write data byte with bits [7:6] equal to 11 is acknowledged, but it changes no register and raises no strobe.
- R6: One write transaction can update several registers, in any order.
- R7: Read bytes come out in the order wiper0, wiper1, cfg_val, and each is returned as {selector, value}. An ACK after cfg_val wraps the sequence back to wiper0.
- R8: A NACK from the master ends a read and leaves SDA released. A STOP releases SDA within one clock.
- R9: A repeated START begins a new transaction exactly as a START does.
- R10: Bits travel MSB first. The block changes its SDA drive only while SCL is low.
- R11: After reset all three registers are zero and neither sda_oe nor any strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap | input | 3 | Low three address bits |
| cs_n | input | 1 | Active-low interface enable |
| wiper0 | output | 6 | First wiper setting |
| wiper1 | output | 6 | Second wiper setting |
| cfg_val | output | 6 | Configuration value |
| wr_stb | output | 3 | One-cycle write strobe per register |

## Verification
Four properties are checked on every cycle:
- SDA is never driven while the block is disabled.
- SDA is released after a STOP.
- The drive only ever rises while the synchronised clock is low.
- At most one strobe is active, and a register changes only in the cycle after its own strobe.

Address matching, selector decoding, the discarded 11 code, the wrap-around read order and the behaviour after a mismatch or a repeated START are shown only by the bench. It drives full bus transactions and compares the acknowledge bits, the bytes read back and the register values.

// File: rtl/wpot_pkg.sv
package wpot_pkg;
    localparam int VAL_W = 6;
    localparam int SEL_W = 2;
    localparam int BYTE_W = VAL_W + SEL_W;
    localparam int NREG = 3;
    localparam int CNT_W = $clog2(BYTE_W);

    typedef enum logic [SEL_W-1:0] {
        SEL_W0   = 2'd0,
        SEL_W1   = 2'd1,
        SEL_CFG  = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_SET,
        ST_ACK_HOLD,
        ST_WR,
        ST_RD,
        ST_MACK,
        ST_RD_LOAD
    } st_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic sel_e sel_next(input sel_e s);
        return (s == SEL_CFG) ? SEL_W0 : sel_e'(s + 2'd1);
    endfunction
endpackage

// File: rtl/wpot_bus_sync.sv
module wpot_bus_sync
    import wpot_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    scl_i,
    input  logic    sda_i,
    output logic    scl_s,
    output logic    sda_s,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_p <= scl_q[STAGES-1];
            sda_p <= sda_q[STAGES-1];
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_comb begin
        ev.rise  = en & scl_s & ~scl_p;
        ev.fall  = en & ~scl_s & scl_p;
        ev.start = en & scl_s & scl_p & sda_p & ~sda_s;
        ev.stop  = en & scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/wpot_regfile.sv
module wpot_regfile
    import wpot_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NREG-1:0]            wr_stb,
    input  logic [VAL_W-1:0]           wr_val,
    output logic [NREG-1:0][VAL_W-1:0] regs
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) regs[i] <= '0;
            else if (wr_stb[i]) regs[i] <= wr_val;
        end
    end
endmodule

// File: rtl/wpot_engine.sv
module wpot_engine
    import wpot_pkg::*;
#(
    parameter logic [3:0] ADDR_PREFIX = 4'b0101
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  bus_ev_t                    ev,
    input  logic                       sda_s,
    input  logic [2:0]                 strap,
    input  logic [NREG-1:0][VAL_W-1:0] regs,
    output logic                       sda_oe,
    output logic [NREG-1:0]            wr_stb,
    output logic [VAL_W-1:0]           wr_val
);
    st_e              st;
    logic [CNT_W-1:0] cnt;
    logic [6:0]       sh;
    logic             rw;
    sel_e             ptr;
    logic [7:0]       tx;
    logic [7:0]       rx;
    logic [7:0]       cur;

    assign rx = {sh, sda_s};

    always_comb begin
        case (ptr)
            SEL_W0:  cur = {ptr, regs[0]};
            SEL_W1:  cur = {ptr, regs[1]};
            SEL_CFG: cur = {ptr, regs[2]};
            default: cur = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            sh     <= '0;
            rw     <= 1'b0;
            ptr    <= SEL_W0;
            tx     <= '0;
            sda_oe <= 1'b0;
            wr_stb <= '0;
            wr_val <= '0;
        end else begin
            wr_stb <= '0;
            if (!en) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.start) begin
                st     <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR: if (ev.rise) begin
                        sh  <= rx[6:0];
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(BYTE_W - 1)) begin
                            if (rx[7:1] == {ADDR_PREFIX, strap}) begin
                                rw  <= rx[0];
                                ptr <= SEL_W0;
                                st  <= ST_ACK_SET;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK_SET: if (ev.fall) begin
                        sda_oe <= 1'b1;
                        st     <= ST_ACK_HOLD;
                    end
                    ST_ACK_HOLD: if (ev.fall) begin
                        cnt <= '0;
                        if (rw) begin
                            tx     <= cur;
                            sda_oe <= ~cur[7];
                            st     <= ST_RD;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= ST_WR;
                        end
                    end
                    ST_WR: if (ev.rise) begin
                        sh  <= rx[6:0];
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(BYTE_W - 1)) begin
                            if (sel_e'(rx[7:6]) != SEL_NONE) begin
                                wr_stb <= NREG'(1) << rx[7:6];
                                wr_val <= rx[VAL_W-1:0];
                            end
                            st <= ST_ACK_SET;
                        end
                    end
                    ST_RD: begin
                        if (ev.rise) begin
                            cnt <= cnt + 1'b1;
                            if (cnt == CNT_W'(BYTE_W - 1)) st <= ST_MACK;
                        end else if (ev.fall) begin
                            tx     <= {tx[6:0], 1'b0};
                            sda_oe <= ~tx[6];
                        end
                    end
                    ST_MACK: begin
                        if (ev.fall) begin
                            sda_oe <= 1'b0;
                        end else if (ev.rise) begin
                            if (!sda_s) begin
                                ptr <= sel_next(ptr);
                                st  <= ST_RD_LOAD;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    ST_RD_LOAD: if (ev.fall) begin
                        cnt    <= '0;
                        tx     <= cur;
                        sda_oe <= ~cur[7];
                        st     <= ST_RD;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/wpot_i2c_regs.sv
module wpot_i2c_regs
    import wpot_pkg::*;
#(
    parameter logic [3:0] ADDR_PREFIX = 4'b0101,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [2:0]       strap,
    input  logic             cs_n,
    output logic [VAL_W-1:0] wiper0,
    output logic [VAL_W-1:0] wiper1,
    output logic [VAL_W-1:0] cfg_val,
    output logic [NREG-1:0]  wr_stb
);
    logic                       scl_s, sda_s, stop_ev;
    bus_ev_t                    ev;
    logic [NREG-1:0][VAL_W-1:0] regs;
    logic [VAL_W-1:0]           wr_val;

    wpot_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .en(~cs_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .ev(ev)
    );

    wpot_engine #(.ADDR_PREFIX(ADDR_PREFIX)) u_engine (
        .clk(clk), .rst(rst), .en(~cs_n), .ev(ev), .sda_s(sda_s),
        .strap(strap), .regs(regs), .sda_oe(sda_oe), .wr_stb(wr_stb),
        .wr_val(wr_val)
    );

    wpot_regfile u_regs (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_val(wr_val), .regs(regs)
    );

    assign stop_ev = ev.stop;
    assign wiper0  = regs[0];
    assign wiper1  = regs[1];
    assign cfg_val = regs[2];
endmodule

// File: rtl/wpot_checker.sv
module wpot_checker
    import wpot_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             sda_oe,
    input logic             scl_s,
    input logic             stop_ev,
    input logic [NREG-1:0]  wr_stb,
    input logic [VAL_W-1:0] wiper0,
    input logic [VAL_W-1:0] wiper1,
    input logic [VAL_W-1:0] cfg_val
);
    assert_quiet_disabled_R3: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !sda_oe);

    assert_release_on_stop_R8: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> !sda_oe);

    assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_stb));

    assert_w0_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_stb[0] |=> $stable(wiper0));

    assert_w1_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_stb[1] |=> $stable(wiper1));

    assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_stb[2] |=> $stable(cfg_val));
endmodule

bind wpot_i2c_regs wpot_checker u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sda_oe(sda_oe), .scl_s(scl_s),
    .stop_ev(stop_ev), .wr_stb(wr_stb), .wiper0(wiper0), .wiper1(wiper1),
    .cfg_val(cfg_val)
);

// File: tb/test_wpot_i2c_regs.sv
module test_wpot_i2c_regs;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8;
    localparam logic [7:0] ADDR_W = 8'h5A;
    localparam logic [7:0] ADDR_R = 8'h5B;
    localparam logic [7:0] ADDR_BAD = 8'h58;

    // {data byte, expected wiper0, wiper1, cfg}
    localparam logic [25:0] VEC [8] = '{
        {8'h05, 6'h05, 6'h00, 6'h00},
        {8'h7F, 6'h05, 6'h3F, 6'h00},
        {8'h81, 6'h05, 6'h3F, 6'h01},
        {8'hC9, 6'h05, 6'h3F, 6'h01},
        {8'h3F, 6'h3F, 6'h3F, 6'h01},
        {8'h40, 6'h3F, 6'h00, 6'h01},
        {8'hBE, 6'h3F, 6'h00, 6'h3E},
        {8'h00, 6'h00, 6'h00, 6'h3E}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic cs_n = 1'b0;
    logic [2:0] strap = 3'b101;
    logic sda_oe;
    logic [5:0] wiper0, wiper1, cfg_val;
    logic [2:0] wr_stb;
    wire sda_line = m_sda & ~sda_oe;

    int n_chk = 0;
    int n_fail = 0;
    int stb_cnt [3] = '{0, 0, 0};
    int oe_high_changes = 0;
    int cyc = 0;
    logic oe_prev = 1'b0;
    logic scl_prev = 1'b1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wpot_i2c_regs i_wpot_i2c_regs (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap(strap), .cs_n(cs_n), .wiper0(wiper0), .wiper1(wiper1),
        .cfg_val(cfg_val), .wr_stb(wr_stb)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            for (int k = 0; k < 3; k++) if (wr_stb[k]) stb_cnt[k]++;
            if (scl && scl_prev && (sda_oe != oe_prev)) oe_high_changes++;
        end
        oe_prev  <= sda_oe;
        scl_prev <= scl;
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc == 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
            finish_run();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_cyc(HALF);
        scl = 1'b1;   wait_cyc(HALF);
        m_sda = 1'b0; wait_cyc(HALF);
        scl = 1'b0;   wait_cyc(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_cyc(HALF);
        scl = 1'b1;   wait_cyc(HALF);
        m_sda = 1'b1; wait_cyc(HALF);
    endtask

    task automatic send_bit(input logic b);
        wait_cyc(2);
        m_sda = b; wait_cyc(HALF);
        scl = 1'b1; wait_cyc(HALF);
        scl = 1'b0;
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; wait_cyc(HALF + 2);
        scl = 1'b1;   wait_cyc(HALF / 2);
        b = sda_line; wait_cyc(HALF / 2);
        scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic master_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~master_ack);
    endtask

    initial begin
        logic       a;
        logic [7:0] rd;
        int         exp_stb [3];
        exp_stb = '{0, 0, 0};

        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(3);
        // R11 reset state
        chk("R11 wiper0", wiper0, 0);
        chk("R11 wiper1", wiper1, 0);
        chk("R11 cfg_val", cfg_val, 0);
        chk("R11 sda_oe", sda_oe, 0);
        chk("R11 wr_stb", wr_stb, 0);

        // R4/R5 table walk: one single-byte write per entry
        for (int i = 0; i < 8; i++) begin
            logic [25:0] e;
            e = VEC[i];
            bus_start();
            send_byte(ADDR_W, a);
            chk("R1 address ack", a, 1);
            send_byte(e[25:18], a);
            chk("R5 data ack", a, 1);
            bus_stop();
            if (e[25:24] != 2'b11) exp_stb[e[25:24]]++;
            chk("R4 wiper0", wiper0, e[17:12]);
            chk("R4 wiper1", wiper1, e[11:6]);
            chk("R4 cfg_val", cfg_val, e[5:0]);
            for (int k = 0; k < 3; k++) chk("R5 strobe count", stb_cnt[k], exp_stb[k]);
        end

        // R6 multi-byte write in mixed order, with an ignored 11 byte
        bus_start();
        send_byte(ADDR_W, a);
        send_byte(8'h8A, a);
        send_byte(8'h15, a);
        send_byte(8'hC0, a);
        chk("R5 ack of 11 selector", a, 1);
        send_byte(8'h6A, a);
        bus_stop();
        chk("R6 wiper0", wiper0, 6'h15);
        chk("R6 wiper1", wiper1, 6'h2A);
        chk("R6 cfg_val", cfg_val, 6'h0A);

        // R7 read order, selector prefix and wrap; R10 MSB first
        bus_start();
        send_byte(ADDR_R, a);
        chk("R1 read address ack", a, 1);
        recv_byte(rd, 1'b1);
        chk("R7 first byte", rd, 8'h15);
        recv_byte(rd, 1'b1);
        chk("R7 second byte", rd, 8'h6A);
        recv_byte(rd, 1'b1);
        chk("R7 third byte", rd, 8'h8A);
        recv_byte(rd, 1'b0);
        chk("R7 wrapped byte", rd, 8'h15);
        wait_cyc(HALF);
        // R8 release after NACK
        chk("R8 sda_oe after NACK", sda_oe, 0);
        chk("R8 line high after NACK", sda_line, 1);
        bus_stop();
        chk("R8 sda_oe after STOP", sda_oe, 0);

        // R2 mismatch ignored until the next START
        bus_start();
        send_byte(ADDR_BAD, a);
        chk("R2 no ack on mismatch", a, 0);
        send_byte(8'h2B, a);
        chk("R2 no ack on data", a, 0);
        bus_stop();
        chk("R2 wiper0 unchanged", wiper0, 6'h15);

        // R9 repeated START: write then read back without STOP
        bus_start();
        send_byte(ADDR_W, a);
        send_byte(8'h12, a);
        bus_start();
        send_byte(ADDR_R, a);
        chk("R9 ack after repeated start", a, 1);
        recv_byte(rd, 1'b0);
        chk("R9 readback", rd, 8'h12);
        bus_stop();

        // R3 disabled interface
        cs_n = 1'b1;
        wait_cyc(4);
        bus_start();
        send_byte(ADDR_W, a);
        chk("R3 no ack when disabled", a, 0);
        send_byte(8'h0F, a);
        bus_stop();
        chk("R3 wiper0 unchanged", wiper0, 6'h12);
        cs_n = 1'b0;
        wait_cyc(4);

        // R1 strap change moves the address
        strap = 3'b010;
        bus_start();
        send_byte(ADDR_W, a);
        chk("R1 old address rejected", a, 0);
        bus_stop();
        bus_start();
        send_byte(8'h54, a);
        chk("R1 new address ack", a, 1);
        send_byte(8'h7C, a);
        bus_stop();
        chk("R1 write via new address", wiper1, 6'h3C);

        chk("R10 drive changes while SCL high", oe_high_changes, 0);
        finish_run();
    end
endmodule